// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block is a small performance monitoring unit, read and written through a plain register port. It holds a read-only capability word, one read-only capability word for each event group, one configuration register and one value register per counter, a sticky overflow status register and a freeze register. Software finds out how many counters there are, how wide they are and which features exist by reading the capability word. It then programs each counter's event selection and overflow behaviour, and reads the counts.

Counter 0 is a fixed-function counter that counts clock ticks. Its event group and event mask are constants. The other counters are configurable. Each configurable counter selects event group 0 (the clock-tick group, mask bit 0) or event group 1 (the event input vector). In group 1 the counter adds, every cycle, the number of event inputs that are both asserted and selected by its mask. Counters stop while their freeze bit is set, but software can still write them. A counter that wraps sets its overflow bit. Depending on its configuration, it also raises the interrupt output or freezes every counter. All accesses are 64 bits wide and aligned to 8 bytes.

Top module: `pmu_unit`

## Requirements
- R1: After reset, every counter value reads 0, the overflow and freeze registers read 0 and `irq` is low. Configuration of counter 0 reads 0x0000_0000_0100_0001 (kind 1, mask bit 24 set). Configuration of counters 1 to 3 reads 0x2.
- R2: The capability word at offset 0x000 reads 0x1007_0000_0010_3003 with default parameters. The fields are: counters minus one in bits 4:0, counter width in bits 15:8, event groups minus one in bits 24:20, interrupt vector in bits 47:44 (0), writable-while-frozen in bit 48, freeze support in bit 49, interrupt support in bit 50, and version in bits 63:60 (1). Writes to it have no effect.
- R3: The group capability at 0x100 reads mask 0x1 in bits 31:0, group id 0 in bits 47:32 and vendor id 0xA5C3 in bits 63:48. The one at 0x108 reads mask 0xFF, group id 0x0010 and the same vendor id.
- R4: Configuration n is at 0x200+8n. The kind is in bits 1:0 (0 free-running, 1 fixed, 2 configurable), enable in bit 8, interrupt-on-overflow in bit 9, freeze-on-overflow in bit 10, event mask in bits 55:24 and group index in bits 63:59. For counter 0, writes to the kind, mask and group fields are ignored. When enabled and not frozen, counter 0 adds 1 each cycle.
- R5: A configurable counter reports kind 2 and keeps the written mask and group. In group 1 it adds popcount(event inputs AND mask) each cycle. In group 0 with mask bit 0 set it adds 1 each cycle.
- R6: Counter value n at 0xC00+8n is writable whether the counter is frozen or not. A write takes precedence over the increment in the same cycle.
- R7: Freeze register bit n (offset 0x018) stops counter n. Counters whose freeze bit is clear keep counting.
- R8: When counter n wraps from all ones, bit n of the overflow register (0x010) is set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: A wrap on a counter with freeze-on-overflow set sets all freeze bits in the same cycle as the wrap.
- R10: `irq` is high exactly while some counter has both its overflow bit and its interrupt-on-overflow bit set.
- R11: Read data appears on `reg_rdata` one cycle after `reg_rd`. Unmapped offsets, including the filter area at 0x400, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access, 8-byte aligned |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| evt_in | input | 8 | Event inputs for event group 1 |
| irq | output | 1 | Overflow interrupt |

## Verification
The main check sweeps all 256 event input patterns, each over a counting window of a different length. Each pattern is checked against a sparse mask (0x05), a full mask and the two clock-tick counters. This separates mask gating, population counting and the choice between the tick group and the event group.

Further patterns check the boundaries:
- freezing a single counter, to separate per-counter freeze from global freeze;
- a value write inside a counting window, to show that the write takes precedence;
- wraps with interrupt enabled, with freeze enabled and with neither, to separate the sticky overflow flag from the interrupt and from the freeze reaction.

// File: rtl/pmu_pkg.sv
// Shared offsets, field positions and counter kinds of the counter unit.
// Assumes 64-bit registers on 8-byte aligned byte offsets.
package pmu_pkg;

    localparam logic [11:0] OFS_CAP   = 12'h000;
    localparam logic [11:0] OFS_OVF   = 12'h010;
    localparam logic [11:0] OFS_FRZ   = 12'h018;
    localparam logic [11:0] OFS_EVCAP = 12'h100;
    localparam logic [11:0] OFS_CFG   = 12'h200;
    localparam logic [11:0] OFS_VAL   = 12'hC00;

    // configuration field positions
    localparam int unsigned CFG_EN_BIT   = 8;
    localparam int unsigned CFG_IRQ_BIT  = 9;
    localparam int unsigned CFG_FRZ_BIT  = 10;
    localparam int unsigned CFG_MASK_LSB = 24;
    localparam int unsigned CFG_GRP_LSB  = 59;

    // capability field positions
    localparam int unsigned CAP_NCNT_LSB = 0;
    localparam int unsigned CAP_WID_LSB  = 8;
    localparam int unsigned CAP_NGRP_LSB = 20;
    localparam int unsigned CAP_VEC_LSB  = 44;
    localparam int unsigned CAP_WWF_BIT  = 48;
    localparam int unsigned CAP_FRZ_BIT  = 49;
    localparam int unsigned CAP_INT_BIT  = 50;
    localparam int unsigned CAP_VER_LSB  = 60;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_FIXED = 2'd1,
        KIND_CONF  = 2'd2
    } cnt_kind_e;

endpackage

// File: rtl/pmu_event_sel.sv
// Per-counter increment selection.
// Group 0 is the clock-tick group: it adds mask bit 0 every cycle.
// Group 1 adds the number of event inputs that are asserted and selected
// by the mask. Any other group adds nothing.
// Assumes EVT_W fits the 32-bit mask field.
module pmu_event_sel #(
    parameter int unsigned EVT_W = 8,
    parameter int unsigned GRP_W = 1,
    parameter int unsigned INC_W = $clog2(EVT_W + 1)
) (
    input  logic [EVT_W-1:0] evt_in,
    input  logic [EVT_W-1:0] mask,
    input  logic [GRP_W-1:0] grp,
    output logic [INC_W-1:0] inc
);

    logic [EVT_W-1:0] masked;
    logic [INC_W-1:0] ones;

    // population count of the selected, asserted events
    always_comb begin
        masked = evt_in & mask;
        ones   = '0;
        for (int i = 0; i < EVT_W; i++) begin
            ones = ones + INC_W'(masked[i]);
        end
    end

    // choose the increment by event group
    always_comb begin
        if (grp == '0) begin
            inc = INC_W'(mask[0]);
        end else if (grp == GRP_W'(1)) begin
            inc = ones;
        end else begin
            inc = '0;
        end
    end

endmodule

// File: rtl/pmu_counter.sv
// One counter slice: configuration fields, value register and wrap detection.
// IS_FIXED selects a fixed-function slice, whose mask is 1 and group is 0
// as constants, or a configurable slice with writable mask and group.
// A value write takes precedence over the increment and suppresses a wrap.
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int unsigned CNT_W    = 48,
    parameter int unsigned EVT_W    = 8,
    parameter int unsigned GRP_W    = 1,
    parameter int unsigned INC_W    = $clog2(EVT_W + 1),
    parameter bit          IS_FIXED = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             val_we,
    input  logic [63:0]      wdata,
    input  logic [EVT_W-1:0] evt_in,
    input  logic             frozen,
    output logic [63:0]      cfg_img,
    output logic [CNT_W-1:0] value,
    output logic             wrap,
    output logic             irq_en,
    output logic             frz_en
);

    localparam cnt_kind_e KIND = IS_FIXED ? KIND_FIXED : KIND_CONF;

    logic             en_q;
    logic             irq_q;
    logic             fz_q;
    logic [EVT_W-1:0] mask_q;
    logic [GRP_W-1:0] grp_q;
    logic [CNT_W-1:0] value_q;
    logic [INC_W-1:0] inc;
    logic [CNT_W:0]   sum;
    logic             active;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;

    // control bits common to both kinds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
            fz_q  <= 1'b0;
        end else if (cfg_we) begin
            en_q  <= wdata[CFG_EN_BIT];
            irq_q <= wdata[CFG_IRQ_BIT];
            fz_q  <= wdata[CFG_FRZ_BIT];
        end
    end

    generate
        if (IS_FIXED) begin : g_fixed
            assign mask_q = EVT_W'(1);
            assign grp_q  = '0;
        end else begin : g_conf
            // writable event selection of a configurable slice
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mask_q <= '0;
                    grp_q  <= '0;
                end else if (cfg_we) begin
                    mask_q <= wdata[CFG_MASK_LSB +: EVT_W];
                    grp_q  <= wdata[CFG_GRP_LSB +: GRP_W];
                end
            end
        end
    endgenerate

    pmu_event_sel #(
        .EVT_W (EVT_W),
        .GRP_W (GRP_W),
        .INC_W (INC_W)
    ) u_sel (
        .evt_in (evt_in),
        .mask   (mask_q),
        .grp    (grp_q),
        .inc    (inc)
    );

    assign active = en_q && !frozen;
    assign sum    = {1'b0, value_q} + (CNT_W + 1)'(inc);
    assign wrap   = active && !val_we && sum[CNT_W];

    // count value: software write, else increment while active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (val_we) begin
            value_q <= wdata[CNT_W-1:0];
        end else if (active) begin
            value_q <= sum[CNT_W-1:0];
        end
    end

    // read image of the configuration register
    always_comb begin
        cfg_img                          = '0;
        cfg_img[1:0]                     = KIND;
        cfg_img[CFG_EN_BIT]              = en_q;
        cfg_img[CFG_IRQ_BIT]             = irq_q;
        cfg_img[CFG_FRZ_BIT]             = fz_q;
        cfg_img[CFG_MASK_LSB +: EVT_W]   = mask_q;
        cfg_img[CFG_GRP_LSB +: GRP_W]    = grp_q;
    end

    assign value  = value_q;
    assign irq_en = irq_q;
    assign frz_en = fz_q;

endmodule

// File: rtl/pmu_unit.sv
// Register-mapped performance counter unit.
// Decodes 64-bit aligned accesses and holds the overflow and freeze
// registers. Builds the capability words and returns registered read data.
// Counters 0..NUM_FIXED-1 are fixed clock-tick counters; the others are
// configurable. Assumes NUM_CNT <= 32 and EVT_W <= 32.
module pmu_unit
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CNT   = 4,
    parameter int unsigned CNT_W     = 48,
    parameter int unsigned EVT_W     = 8,
    parameter int unsigned NUM_FIXED = 1,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] EVT_GID   = 16'h0010,
    parameter logic [3:0]  IRQ_VEC   = 4'd0,
    parameter logic [3:0]  VERSION   = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    output logic              irq
);

    localparam int unsigned NUM_GRP = 2;
    localparam int unsigned GRP_W   = $clog2(NUM_GRP);
    localparam int unsigned INC_W   = $clog2(EVT_W + 1);

    logic [63:0]            cfg_img [NUM_CNT];
    logic [CNT_W-1:0]       cnt_val [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [NUM_CNT-1:0]     cfg_we;
    logic [NUM_CNT-1:0]     val_we;
    logic [NUM_CNT-1:0]     wrap;
    logic [NUM_CNT-1:0]     int_vec;
    logic [NUM_CNT-1:0]     fz_vec;
    logic [NUM_CNT-1:0]     ovf_q;
    logic [NUM_CNT-1:0]     frz_q;
    logic                   ovf_we;
    logic                   frz_we;
    logic [63:0]            cap_word;
    logic [63:0]            rd_mux;

    assign ovf_we = reg_wr && (reg_addr == ADDR_W'(OFS_OVF));
    assign frz_we = reg_wr && (reg_addr == ADDR_W'(OFS_FRZ));

    generate
        for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
            assign cfg_we[n] = reg_wr &&
                (reg_addr == ADDR_W'(32'(OFS_CFG) + 32'(8 * n)));
            assign val_we[n] = reg_wr &&
                (reg_addr == ADDR_W'(32'(OFS_VAL) + 32'(8 * n)));

            pmu_counter #(
                .CNT_W    (CNT_W),
                .EVT_W    (EVT_W),
                .GRP_W    (GRP_W),
                .INC_W    (INC_W),
                .IS_FIXED (n < NUM_FIXED)
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg_we  (cfg_we[n]),
                .val_we  (val_we[n]),
                .wdata   (reg_wdata),
                .evt_in  (evt_in),
                .frozen  (frz_q[n]),
                .cfg_img (cfg_img[n]),
                .value   (cnt_val[n]),
                .wrap    (wrap[n]),
                .irq_en  (int_vec[n]),
                .frz_en  (fz_vec[n])
            );

            assign cnt_flat[n*CNT_W +: CNT_W] = cnt_val[n];
        end
    endgenerate

    // sticky overflow flags, write one to clear, new wraps win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~(ovf_we ? reg_wdata[NUM_CNT-1:0] : '0)) | wrap;
        end
    end

    // freeze bits, set in full by a freeze-on-overflow wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_q <= '0;
        end else begin
            if (frz_we) begin
                frz_q <= reg_wdata[NUM_CNT-1:0];
            end
            if (|(wrap & fz_vec)) begin
                frz_q <= '1;
            end
        end
    end

    assign irq = |(ovf_q & int_vec);

    // constant capability word
    always_comb begin
        cap_word                        = '0;
        cap_word[CAP_NCNT_LSB +: 5]     = 5'(NUM_CNT - 1);
        cap_word[CAP_WID_LSB +: 8]      = 8'(CNT_W);
        cap_word[CAP_NGRP_LSB +: 5]     = 5'(NUM_GRP - 1);
        cap_word[CAP_VEC_LSB +: 4]      = IRQ_VEC;
        cap_word[CAP_WWF_BIT]           = 1'b1;
        cap_word[CAP_FRZ_BIT]           = 1'b1;
        cap_word[CAP_INT_BIT]           = 1'b1;
        cap_word[CAP_VER_LSB +: 4]      = VERSION;
    end

    // read-back selection by offset; unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(OFS_CAP)) begin
            rd_mux = cap_word;
        end
        if (reg_addr == ADDR_W'(OFS_OVF)) begin
            rd_mux = 64'(ovf_q);
        end
        if (reg_addr == ADDR_W'(OFS_FRZ)) begin
            rd_mux = 64'(frz_q);
        end
        if (reg_addr == ADDR_W'(OFS_EVCAP)) begin
            rd_mux = {VENDOR_ID, 16'h0000, 32'h1};
        end
        if (reg_addr == ADDR_W'(32'(OFS_EVCAP) + 32'd8)) begin
            rd_mux = {VENDOR_ID, EVT_GID, 32'({EVT_W{1'b1}})};
        end
        for (int n = 0; n < NUM_CNT; n++) begin
            if (reg_addr == ADDR_W'(32'(OFS_CFG) + 32'(8 * n))) begin
                rd_mux = cfg_img[n];
            end
            if (reg_addr == ADDR_W'(32'(OFS_VAL) + 32'(8 * n))) begin
                rd_mux = 64'(cnt_val[n]);
            end
        end
    end

    // registered read data, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/pmu_unit_chk.sv
// Checker for pmu_unit, attached by bind. Watches the register port,
// the overflow and freeze registers and the counter values.
module pmu_unit_chk
    import pmu_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned CNT_W   = 48,
    parameter int unsigned ADDR_W  = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic                     reg_rd,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [63:0]              reg_rdata,
    input logic                     irq,
    input logic [NUM_CNT-1:0]       ovf_q,
    input logic [NUM_CNT-1:0]       frz_q,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

    logic ovf_wr;
    logic frz_wr;

    assign ovf_wr = reg_wr && (reg_addr == ADDR_W'(OFS_OVF));
    assign frz_wr = reg_wr && (reg_addr == ADDR_W'(OFS_FRZ));

    AST_CAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_CAP)) |=>
        (reg_rdata[15:8] == 8'(CNT_W) && reg_rdata[4:0] == 5'(NUM_CNT - 1))); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_wr |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R8

    AST_FRZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_wr |=> ((frz_q & $past(frz_q)) == $past(frz_q))); // R9

    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q != '0)); // R10

    generate
        for (genvar n = 0; n < NUM_CNT; n++) begin : g_chk
            logic val_wr;
            assign val_wr = reg_wr &&
                (reg_addr == ADDR_W'(32'(OFS_VAL) + 32'(8 * n)));

            AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (frz_q[n] && !val_wr) |=>
                (cnt_flat[n*CNT_W +: CNT_W] == $past(cnt_flat[n*CNT_W +: CNT_W]))); // R7

            AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
                (!val_wr && !ovf_wr && !frz_q[n]) |=>
                ((cnt_flat[n*CNT_W +: CNT_W] < $past(cnt_flat[n*CNT_W +: CNT_W]))
                 ? ovf_q[n] : 1'b1)); // R8
        end
    endgenerate

endmodule

bind pmu_unit pmu_unit_chk #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .ovf_q     (ovf_q),
    .frz_q     (frz_q),
    .cnt_flat  (cnt_flat)
);

// File: tb/tb_pmu_unit.sv
`timescale 1ns/1ps
module tb_pmu_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [7:0]  evt_in = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_CAP = 12'h000;
    localparam logic [11:0] A_OVF = 12'h010;
    localparam logic [11:0] A_FRZ = 12'h018;
    localparam logic [63:0] TOP3  = 64'h0000_FFFF_FFFF_FFFD;

    always #2.5 clk = ~clk;

    pmu_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .irq       (irq)
    );

    function automatic logic [11:0] a_cfg(int n);
        return 12'h200 + 12'(8 * n);
    endfunction

    function automatic logic [11:0] a_val(int n);
        return 12'hC00 + 12'(8 * n);
    endfunction

    function automatic int pop8(logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write lands at the next posedge
    task automatic wr(logic [11:0] a, logic [63:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [63:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic expect_reg(string tag, logic [11:0] a, logic [63:0] e);
        logic [63:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    // open a window: counters not in keep count for m+1 cycles
    task automatic run_win(logic [3:0] keep, int m);
        wr(A_FRZ, 64'(keep));
        repeat (m) @(negedge clk);
        wr(A_FRZ, 64'hF);
    endtask

    task automatic zero_all();
        for (int n = 0; n < 4; n++) wr(a_val(n), 64'h0);
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", 64'(irq), 64'h0);
        expect_reg("R1 ovf reset", A_OVF, 64'h0);
        expect_reg("R1 frz reset", A_FRZ, 64'h0);
        expect_reg("R1 cfg0 reset", a_cfg(0), 64'h0000_0000_0100_0001);
        for (int n = 1; n < 4; n++) expect_reg("R1 cfgN reset", a_cfg(n), 64'h2);
        for (int n = 0; n < 4; n++) expect_reg("R1 value reset", a_val(n), 64'h0);

        // R2 capability, write ignored
        expect_reg("R2 cap word", A_CAP, 64'h1007_0000_0010_3003);
        wr(A_CAP, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_reg("R2 cap after write", A_CAP, 64'h1007_0000_0010_3003);

        // R3 group capabilities
        expect_reg("R3 group0 cap", 12'h100, 64'hA5C3_0000_0000_0001);
        expect_reg("R3 group1 cap", 12'h108, 64'hA5C3_0010_0000_00FF);

        // R11 unmapped offsets
        expect_reg("R11 unmapped 0x008", 12'h008, 64'h0);
        expect_reg("R11 filter 0x400", 12'h400, 64'h0);
        expect_reg("R11 unmapped 0x220", 12'h220, 64'h0);
        expect_reg("R11 unmapped 0xC20", 12'hC20, 64'h0);

        // programming while frozen
        wr(A_FRZ, 64'hF);
        wr(a_cfg(0), 64'hF8FF_FFFF_0000_0103);
        expect_reg("R4 fixed cfg read-only fields", a_cfg(0), 64'h0000_0000_0100_0101);
        wr(a_cfg(1), 64'h0800_0000_0500_0100);
        expect_reg("R5 conf cfg group1 mask05", a_cfg(1), 64'h0800_0000_0500_0102);
        wr(a_cfg(2), 64'h0000_0000_0100_0100);
        expect_reg("R5 conf cfg group0 tick", a_cfg(2), 64'h0000_0000_0100_0102);
        wr(a_cfg(3), 64'h0800_0000_FF00_0100);
        expect_reg("R5 conf cfg group1 maskFF", a_cfg(3), 64'h0800_0000_FF00_0102);

        // R4 R5 sweep over every event pattern
        for (int p = 0; p < 256; p++) begin
            int m;
            m = (p % 5) + 1;
            evt_in = p[7:0];
            zero_all();
            run_win(4'h0, m);
            expect_reg("R4 fixed tick count", a_val(0), 64'(m + 1));
            expect_reg("R5 sparse mask count", a_val(1), 64'((m + 1) * pop8(p[7:0] & 8'h05)));
            expect_reg("R5 group0 tick count", a_val(2), 64'(m + 1));
            expect_reg("R5 full mask count", a_val(3), 64'((m + 1) * pop8(p[7:0])));
        end

        // R7 single-counter freeze
        evt_in = 8'hFF;
        zero_all();
        run_win(4'b0010, 4);
        expect_reg("R7 frozen counter holds", a_val(1), 64'h0);
        expect_reg("R7 other counter runs", a_val(0), 64'd5);
        expect_reg("R7 other counter events", a_val(3), 64'd40);

        // R6 write precedence inside a window
        zero_all();
        wr(A_FRZ, 64'h0);
        wr(a_val(0), 64'd1000);
        repeat (3) @(negedge clk);
        wr(A_FRZ, 64'hF);
        expect_reg("R6 write wins over increment", a_val(0), 64'd1004);
        expect_reg("R6 neighbour kept counting", a_val(2), 64'd5);
        wr(a_val(0), 64'h1234);
        expect_reg("R6 write while frozen", a_val(0), 64'h1234);

        // R8 wrap and write-one-to-clear
        evt_in = 8'h00;
        zero_all();
        wr(a_val(0), TOP3);
        run_win(4'h0, 4);
        expect_reg("R8 wrapped value", a_val(0), 64'd2);
        expect_reg("R8 overflow flag", A_OVF, 64'h1);
        chk("R10 irq low without enable", 64'(irq), 64'h0);
        wr(A_OVF, 64'h0);
        expect_reg("R8 write zero keeps flag", A_OVF, 64'h1);
        wr(A_OVF, 64'h1);
        expect_reg("R8 write one clears", A_OVF, 64'h0);

        // R10 interrupt
        wr(a_cfg(0), 64'h300);
        wr(a_val(0), TOP3);
        run_win(4'h0, 4);
        chk("R10 irq on enabled overflow", 64'(irq), 64'h1);
        wr(a_cfg(0), 64'h100);
        chk("R10 irq drops with enable off", 64'(irq), 64'h0);
        wr(a_cfg(0), 64'h300);
        chk("R10 irq returns with enable on", 64'(irq), 64'h1);
        wr(A_OVF, 64'hF);
        chk("R10 irq drops after clear", 64'(irq), 64'h0);

        // R9 freeze on overflow
        evt_in = 8'hFF;
        zero_all();
        wr(a_cfg(0), 64'h500);
        wr(a_val(0), TOP3);
        wr(A_FRZ, 64'h0);
        repeat (6) @(negedge clk);
        expect_reg("R9 all frozen", A_FRZ, 64'hF);
        expect_reg("R9 wrapped counter stops", a_val(0), 64'h0);
        expect_reg("R9 tick counter stopped", a_val(2), 64'd3);
        expect_reg("R9 event counter stopped", a_val(3), 64'd24);
        expect_reg("R9 overflow flag", A_OVF, 64'h1);
        chk("R9 no irq without enable", 64'(irq), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule